// File: doc/BRIEF.md
# Instruction Cache with Flash Invalidation

A direct-mapped instruction cache that serves 32-bit instructions to a fetch stage. Each data RAM entry is a 64-bit doubleword holding two instructions, and a line is eight doublewords (64 bytes). On a miss, the cache reloads the line over a pipelined Wishbone-style read master. Bus addresses are in doubleword units. A lookup is resolved in the request cycle. The instruction appears on `insn_o`, with `insn_valid_o` set, in the following cycle.

When fetch marks a request as sequential and the request addresses the upper word of a doubleword, the cache can reuse the doubleword it read in the previous cycle. This needs the previous cycle to have been served. The reuse path never stalls and never starts a reload, so an instruction is not delivered twice.

A single-cycle `flush_i` clears every valid bit. A flush can arrive while a line is being cleared or filled. In that case the reload drops into an abort state: it issues no further reads, drains every acknowledge it is still owed, and returns to idle. The aborted line is never marked valid.

Top module: `insn_cache`

## Requirements
- R1: After reset, `insn_valid_o`, `wb_cyc_o`, `wb_stb_o` and `miss_o` are low, and `stall_o` is low while `fetch_req_i` is low.
- R2: A request that hits returns, in the next cycle, the word selected by address bit 2 of the cached doubleword (bit 2 = 0 selects bits 31:0, bit 2 = 1 selects bits 63:32), with `insn_valid_o` high.
- R3: A request that neither hits nor reuses holds `stall_o` high. If the reload engine is idle, `miss_o` is high for that one cycle and a line reload starts.
- R4: A reload issues eight reads, for doublewords 0 to 7 of the line in order. The address is the byte address shifted right by 3. The k-th acknowledge's data is written to doubleword k of the line.
- R5: After the eighth acknowledge with no flush in that cycle, the line is valid, and later requests to it hit with `stall_o` low.
- R6: A request with `fetch_seq_i` high and address bit 2 high, issued the cycle after a served request, is served from the upper word of the previous read. `stall_o` and `miss_o` stay low in that cycle.
- R7: `flush_i` clears all valid bits at the clock edge where it is sampled. A request to a previously cached line after that edge misses.
- R8: A flush sampled while the line is being cleared or filled sends the reload into the abort state. The line stays invalid, so the still-pending request starts a second reload.
- R9: In the abort state, no new reads are issued. `wb_cyc_o` drops only once every issued read has been acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_req_i | input | 1 | Fetch request |
| fetch_addr_i | input | ADDR_W | Fetch byte address |
| fetch_seq_i | input | 1 | Address equals the previous cycle's address plus 4 |
| flush_i | input | 1 | Flash invalidate of all lines |
| insn_o | output | 32 | Instruction for the request served in the previous cycle |
| insn_valid_o | output | 1 | `insn_o` is valid |
| stall_o | output | 1 | Request not served this cycle |
| miss_o | output | 1 | Reload starts this cycle |
| wb_cyc_o | output | 1 | Bus cycle active |
| wb_stb_o | output | 1 | Read request strobe |
| wb_adr_o | output | ADDR_W-3 | Doubleword address |
| wb_stall_i | input | 1 | Bus cannot accept a request |
| wb_ack_i | input | 1 | Read data acknowledge |
| wb_dat_i | input | 64 | Read data |

## Verification
The bench runs three kinds of fetch sequences:
- Random fetches spread over three tags that compete for the same sets. These exercise cold misses, conflict evictions and hits.
- Chained sequential fetches. Only these can take the reuse path, and each upper-word step must be served without a stall.
- Flushes placed in the clear cycle or in mid-fill. Here the count of reload starts separates a correct abort (two starts) from a line that was wrongly validated (one start).

A bus model with random stall and acknowledge gaps tracks outstanding reads. It returns data computed from the address, so an out-of-order or misaddressed fill shows up as a wrong instruction.

// File: rtl/icache_pkg.sv
package icache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CLEAR,
    ST_FILL,
    ST_ABORT
  } rl_state_e;
endpackage

// File: rtl/icache_tags.sv
module icache_tags #(
  parameter int NUM_LINES = 8,
  parameter int TAG_W     = 23,
  localparam int IDX_W    = $clog2(NUM_LINES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] lk_idx_i,
  input  logic [TAG_W-1:0] lk_tag_i,
  output logic             hit_o,
  input  logic             flush_i,
  input  logic             clr_i,
  input  logic             set_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [TAG_W-1:0] wr_tag_i
);
  logic [NUM_LINES-1:0] valid_q;
  logic [TAG_W-1:0]     tag_q [NUM_LINES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      for (int i = 0; i < NUM_LINES; i++) tag_q[i] <= '0;
    end else begin
      if (clr_i) begin
        valid_q[wr_idx_i] <= 1'b0;
        tag_q[wr_idx_i]   <= wr_tag_i;
      end
      if (set_i) valid_q[wr_idx_i] <= 1'b1;
      if (flush_i) valid_q <= '0;
    end
  end

  assign hit_o = valid_q[lk_idx_i] && (tag_q[lk_idx_i] == lk_tag_i);

  AST_FLUSH_CLEARS_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (valid_q == '0)); // R7
  AST_NO_SET_ON_FLUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |-> !flush_i); // R8
endmodule

// File: rtl/icache_data.sv
module icache_data #(
  parameter int NUM_LINES = 8,
  parameter int LINE_DW   = 8,
  localparam int RAM_AW   = $clog2(NUM_LINES) + $clog2(LINE_DW),
  localparam int DEPTH    = NUM_LINES * LINE_DW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_en_i,
  input  logic [RAM_AW-1:0] rd_idx_i,
  input  logic              sel_en_i,
  input  logic              sel_hi_i,
  input  logic              wr_en_i,
  input  logic [RAM_AW-1:0] wr_idx_i,
  input  logic [63:0]       wr_data_i,
  output logic [31:0]       insn_o
);
  logic [63:0] ram_q [DEPTH];
  logic [63:0] rdata_q;
  logic        hi_q;

  always_ff @(posedge clk_i) begin
    if (wr_en_i) ram_q[wr_idx_i] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      hi_q    <= 1'b0;
    end else begin
      if (rd_en_i)  rdata_q <= ram_q[rd_idx_i];
      if (sel_en_i) hi_q    <= sel_hi_i;
    end
  end

  assign insn_o = hi_q ? rdata_q[63:32] : rdata_q[31:0];
endmodule

// File: rtl/icache_reload.sv
module icache_reload
  import icache_pkg::*;
#(
  parameter int LINE_DW  = 8,
  parameter int LINE_AW  = 26,
  localparam int OFF_W   = $clog2(LINE_DW),
  localparam int CNT_W   = OFF_W + 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic [LINE_AW-1:0]       line_i,
  input  logic                     flush_i,
  input  logic                     bus_stall_i,
  input  logic                     bus_ack_i,
  output logic                     bus_cyc_o,
  output logic                     bus_stb_o,
  output logic [LINE_AW+OFF_W-1:0] bus_adr_o,
  output rl_state_e                state_o,
  output logic                     clr_o,
  output logic                     set_o,
  output logic [LINE_AW-1:0]       line_o,
  output logic                     fill_we_o,
  output logic [OFF_W-1:0]         fill_dw_o
);
  localparam logic [CNT_W-1:0] LAST_ACK = CNT_W'(LINE_DW - 1);
  localparam logic [CNT_W-1:0] ALL_REQ  = CNT_W'(LINE_DW);

  rl_state_e          state_q, state_d;
  logic [CNT_W-1:0]   req_cnt_q, ack_cnt_q;
  logic [LINE_AW-1:0] line_q;
  logic               accept, last_ack, drained_fill, drained_abort;

  assign bus_cyc_o = (state_q == ST_FILL) || (state_q == ST_ABORT);
  assign bus_stb_o = (state_q == ST_FILL) && (req_cnt_q < ALL_REQ);
  assign bus_adr_o = {line_q, req_cnt_q[OFF_W-1:0]};
  assign accept    = bus_stb_o && !bus_stall_i;
  assign last_ack  = bus_ack_i && (ack_cnt_q == LAST_ACK);

  // all issued reads (including one accepted this cycle) acknowledged
  assign drained_fill  = (ack_cnt_q + CNT_W'(bus_ack_i)) == (req_cnt_q + CNT_W'(accept));
  assign drained_abort = (ack_cnt_q + CNT_W'(bus_ack_i)) == req_cnt_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_i) state_d = ST_CLEAR;
      ST_CLEAR: state_d = flush_i ? ST_ABORT : ST_FILL;
      ST_FILL: begin
        if (flush_i)       state_d = drained_fill ? ST_IDLE : ST_ABORT;
        else if (last_ack) state_d = ST_IDLE;
      end
      ST_ABORT: if (drained_abort) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      req_cnt_q <= '0;
      ack_cnt_q <= '0;
      line_q    <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && start_i) begin
        line_q    <= line_i;
        req_cnt_q <= '0;
        ack_cnt_q <= '0;
      end else if (bus_cyc_o) begin
        req_cnt_q <= req_cnt_q + CNT_W'(accept);
        ack_cnt_q <= ack_cnt_q + CNT_W'(bus_ack_i);
      end
    end
  end

  assign state_o   = state_q;
  assign clr_o     = (state_q == ST_CLEAR);
  assign set_o     = (state_q == ST_FILL) && last_ack && !flush_i;
  assign line_o    = line_q;
  assign fill_we_o = bus_ack_i && bus_cyc_o;
  assign fill_dw_o = ack_cnt_q[OFF_W-1:0];

  AST_CLEAR_FLUSH_ABORTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CLEAR && flush_i) |=> (state_q == ST_ABORT)); // R8
  AST_ABORT_HOLDS_REQS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ABORT) |=> $stable(req_cnt_q)); // R9
  AST_ACKS_LE_REQS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_cnt_q <= req_cnt_q); // R9
  AST_REQ_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_cnt_q <= ALL_REQ); // R4
endmodule

// File: rtl/insn_cache.sv
module insn_cache
  import icache_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int NUM_LINES = 8,
  parameter int LINE_DW   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fetch_req_i,
  input  logic [ADDR_W-1:0] fetch_addr_i,
  input  logic              fetch_seq_i,
  input  logic              flush_i,
  output logic [31:0]       insn_o,
  output logic              insn_valid_o,
  output logic              stall_o,
  output logic              miss_o,
  output logic              wb_cyc_o,
  output logic              wb_stb_o,
  output logic [ADDR_W-4:0] wb_adr_o,
  input  logic              wb_stall_i,
  input  logic              wb_ack_i,
  input  logic [63:0]       wb_dat_i
);
  localparam int OFF_W   = $clog2(LINE_DW);
  localparam int IDX_W   = $clog2(NUM_LINES);
  localparam int TAG_W   = ADDR_W - 3 - OFF_W - IDX_W;
  localparam int LINE_AW = TAG_W + IDX_W;
  localparam int RAM_AW  = IDX_W + OFF_W;

  logic               hit, use_prev, served, start;
  logic               prev_ok_q, valid_q;
  rl_state_e          rl_state;
  logic               rl_clr, rl_set, rl_we;
  logic [LINE_AW-1:0] rl_line;
  logic [OFF_W-1:0]   rl_dw;

  // reuse the upper word of last cycle's read: never a miss, never a stall
  assign use_prev = fetch_req_i && fetch_seq_i && fetch_addr_i[2] && prev_ok_q;
  assign served   = use_prev || hit;
  assign stall_o  = fetch_req_i && !served;
  assign start    = stall_o && (rl_state == ST_IDLE);
  assign miss_o   = start;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_ok_q <= 1'b0;
      valid_q   <= 1'b0;
    end else begin
      prev_ok_q <= fetch_req_i && served;
      valid_q   <= fetch_req_i && served;
    end
  end
  assign insn_valid_o = valid_q;

  icache_tags #(
    .NUM_LINES (NUM_LINES),
    .TAG_W     (TAG_W)
  ) u_tags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .lk_idx_i (fetch_addr_i[3+OFF_W +: IDX_W]),
    .lk_tag_i (fetch_addr_i[ADDR_W-1 -: TAG_W]),
    .hit_o    (hit),
    .flush_i  (flush_i),
    .clr_i    (rl_clr),
    .set_i    (rl_set),
    .wr_idx_i (rl_line[IDX_W-1:0]),
    .wr_tag_i (rl_line[LINE_AW-1 -: TAG_W])
  );

  icache_data #(
    .NUM_LINES (NUM_LINES),
    .LINE_DW   (LINE_DW)
  ) u_data (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_en_i   (fetch_req_i && hit && !use_prev),
    .rd_idx_i  (fetch_addr_i[3 +: RAM_AW]),
    .sel_en_i  (fetch_req_i && served),
    .sel_hi_i  (fetch_addr_i[2]),
    .wr_en_i   (rl_we),
    .wr_idx_i  ({rl_line[IDX_W-1:0], rl_dw}),
    .wr_data_i (wb_dat_i),
    .insn_o    (insn_o)
  );

  icache_reload #(
    .LINE_DW (LINE_DW),
    .LINE_AW (LINE_AW)
  ) u_reload (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .line_i      (fetch_addr_i[ADDR_W-1 -: LINE_AW]),
    .flush_i     (flush_i),
    .bus_stall_i (wb_stall_i),
    .bus_ack_i   (wb_ack_i),
    .bus_cyc_o   (wb_cyc_o),
    .bus_stb_o   (wb_stb_o),
    .bus_adr_o   (wb_adr_o),
    .state_o     (rl_state),
    .clr_o       (rl_clr),
    .set_o       (rl_set),
    .line_o      (rl_line),
    .fill_we_o   (rl_we),
    .fill_dw_o   (rl_dw)
  );

  AST_REUSE_NO_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_req_i && fetch_seq_i && fetch_addr_i[2] && $past(fetch_req_i && !stall_o))
      |-> (!stall_o && !miss_o)); // R6
  AST_SERVED_THEN_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_req_i && !stall_o) |=> insn_valid_o); // R2
  AST_MISS_MEANS_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_o |-> stall_o); // R3
  AST_MISS_OPENS_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_o |=> !wb_cyc_o ##1 wb_cyc_o); // R4
endmodule

// File: tb/insn_cache_bench.sv
module insn_cache_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [31:0] addr = '0;
  logic        seq = 1'b0;
  logic        flush = 1'b0;
  logic [31:0] insn;
  logic        insn_valid, stall, miss;
  logic        cyc, stb;
  logic [28:0] adr;
  logic        bstall = 1'b0;
  logic        ack = 1'b0;
  logic [63:0] dat = '0;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  bit bus_err = 1'b0;

  always #2 clk = ~clk;

  insn_cache u_insn_cache (
    .clk_i(clk), .rst_ni(rst_n), .fetch_req_i(req), .fetch_addr_i(addr),
    .fetch_seq_i(seq), .flush_i(flush), .insn_o(insn), .insn_valid_o(insn_valid),
    .stall_o(stall), .miss_o(miss), .wb_cyc_o(cyc), .wb_stb_o(stb), .wb_adr_o(adr),
    .wb_stall_i(bstall), .wb_ack_i(ack), .wb_dat_i(dat)
  );

  function automatic logic [31:0] insn_of(input logic [31:0] a);
    return ((a ^ 32'h3C6E_F372) * 32'h0019_660D) + 32'h1234_5678;
  endfunction

  function automatic logic [63:0] dw_of(input logic [28:0] d);
    return {insn_of({d, 3'b100}), insn_of({d, 3'b000})};
  endfunction

  task automatic chk(input bit ok, input string r, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  // bus model: random stalls, in-order acks with random gaps
  logic [28:0] q_adr [16];
  int unsigned wp = 0, rp = 0;
  always @(posedge clk) begin
    int unsigned rpn, wpn;
    if (!rst_n) begin
      wp = 0; rp = 0; ack <= 1'b0; bstall <= 1'b0;
    end else begin
      if (!cyc && wp != rp) bus_err = 1'b1;
      rpn = rp + (ack ? 1 : 0);
      wpn = wp;
      if (cyc && stb && !bstall) begin
        q_adr[wp % 16] = adr;
        wpn = wp + 1;
      end
      if (wpn != rpn && ($urandom % 4) != 0) begin
        ack <= 1'b1;
        dat <= dw_of(q_adr[rpn % 16]);
      end else begin
        ack <= 1'b0;
        dat <= '0;
      end
      bstall <= (($urandom % 4) == 0);
      rp = rpn;
      wp = wpn;
    end
  end

  // one fetch; flush asserted on stall iteration inv_at (-1: never)
  task automatic fetch(input logic [31:0] a, input bit sq, input int inv_at,
                       output int misses, output bit first_stall, output logic [31:0] got,
                       output bit got_v);
    int n = 0;
    misses = 0;
    first_stall = 1'b0;
    @(negedge clk);
    req = 1'b1; addr = a; seq = sq;
    forever begin
      flush = (n == inv_at);
      #1;
      if (miss) misses++;
      if (n == 0) first_stall = stall;
      if (!stall) break;
      @(negedge clk);
      seq = 1'b0;
      n++;
    end
    @(posedge clk);
    #1;
    flush = 1'b0;
    got = insn;
    got_v = insn_valid;
  endtask

  task automatic idle_flush(input bit f);
    @(negedge clk);
    req = 1'b0; seq = 1'b0; flush = f;
    @(negedge clk);
    flush = 1'b0;
  endtask

  task automatic report;
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    int m; bit fs; logic [31:0] g; bit gv;
    logic [31:0] prev_a;
    bit chain;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    #1;
    chk(insn_valid == 1'b0 && cyc == 1'b0 && stb == 1'b0, "R1 reset outputs", {insn_valid, cyc, stb}, 0);
    chk(stall == 1'b0 && miss == 1'b0, "R1 idle no stall", {stall, miss}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(cyc == 1'b0 && insn_valid == 1'b0, "R1 after release", {cyc, insn_valid}, 0);

    // cold miss, then reuse, then hit in same line
    fetch(32'h0000_1040, 1'b0, -1, m, fs, g, gv);
    chk(fs == 1'b1 && m == 1, "R3 cold miss stall/miss pulse", {fs, m[7:0]}, {1'b1, 8'd1});
    chk(gv && g == insn_of(32'h0000_1040), "R2 R4 lower word after fill", g, insn_of(32'h0000_1040));
    fetch(32'h0000_1044, 1'b1, -1, m, fs, g, gv);
    chk(fs == 1'b0 && m == 0, "R6 reuse no stall", {fs, m[7:0]}, 0);
    chk(gv && g == insn_of(32'h0000_1044), "R6 reuse upper word", g, insn_of(32'h0000_1044));
    fetch(32'h0000_1078, 1'b0, -1, m, fs, g, gv);
    chk(fs == 1'b0, "R5 line valid hit", fs, 0);
    chk(gv && g == insn_of(32'h0000_1078), "R2 R4 last dw data", g, insn_of(32'h0000_1078));
    fetch(32'h0000_107C, 1'b0, -1, m, fs, g, gv);
    chk(gv && g == insn_of(32'h0000_107C), "R2 upper word by bit 2", g, insn_of(32'h0000_107C));

    // flush then refetch
    idle_flush(1'b1);
    fetch(32'h0000_1048, 1'b0, -1, m, fs, g, gv);
    chk(fs == 1'b1 && m == 1, "R7 miss after flush", {fs, m[7:0]}, {1'b1, 8'd1});
    chk(g == insn_of(32'h0000_1048), "R7 data after refill", g, insn_of(32'h0000_1048));

    // flush during clear cycle
    idle_flush(1'b0);
    fetch(32'h0000_2200, 1'b0, 1, m, fs, g, gv);
    chk(m == 2, "R8 flush in clear restarts reload", m, 2);
    chk(g == insn_of(32'h0000_2200), "R8 data after abort", g, insn_of(32'h0000_2200));
    // flush mid-fill
    idle_flush(1'b0);
    fetch(32'h0000_3384, 1'b0, 4, m, fs, g, gv);
    chk(m == 2, "R8 R9 flush mid-fill restarts reload", m, 2);
    chk(g == insn_of(32'h0000_3384), "R9 data after drain", g, insn_of(32'h0000_3384));
    idle_flush(1'b0);
    fetch(32'h0000_3390, 1'b0, -1, m, fs, g, gv);
    chk(fs == 1'b0, "R5 hit after second reload", fs, 0);

    // random phase
    chain = 1'b0;
    prev_a = '0;
    for (int i = 0; i < 300; i++) begin
      logic [31:0] a;
      bit sq;
      if (($urandom % 20) == 0) begin
        idle_flush(1'b1);
        chain = 1'b0;
      end
      if (chain && ($urandom % 2) == 0) begin
        a = prev_a + 32'd4; sq = 1'b1;
      end else begin
        a = (($urandom % 3) << 9) | ($urandom & 32'h1FC); sq = 1'b0;
      end
      fetch(a, sq, -1, m, fs, g, gv);
      chk(gv && g == insn_of(a), "R2 R4 random fetch data", g, insn_of(a));
      if (sq && a[2]) chk(fs == 1'b0 && m == 0, "R6 random reuse no stall", {fs, m[7:0]}, 0);
      prev_a = a;
      chain = 1'b1;
    end

    idle_flush(1'b0);
    repeat (40) @(negedge clk);
    chk(bus_err == 1'b0, "R9 cycle held until all acks", bus_err, 0);
    chk(cyc == 1'b0, "R9 bus idle at end", cyc, 0);
    report();
  end
endmodule